// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial heart of an SPI master. It takes one word at a time from an external transmit queue, shifts it out most significant bit first on `mosi`, and collects the bits on `miso` into a word that it hands to an external receive queue. The serial clock comes from a 9-bit divider, so the bit rate is the system clock divided by 2·(div+1).

Software-visible settings arrive as plain static inputs. They select the idle clock level, the edge on which data changes, the point where input is sampled, and a word size of 8, 16 or 32 bits. They also hold a module-on switch, a master enable and an option that lets the engine drive slave select on its own. The engine reads the queue head through a pop strobe and writes through a push strobe. A `busy` output marks a word in flight. Word size, divider, clock mode and sample point are captured when a word starts, so a change takes effect on the next word.

Top module: `spi_shift_engine`

## Requirements
- R1: After synchronous reset the engine is idle: `busy`, `tx_pop`, `rx_push` and `mosi` are 0, `ss_n` is 1, and `sck` equals `cfg_cpol`.
- R2: While a word is in flight, each half period of `sck` lasts `cfg_div`+1 clock cycles, so the period is 2·(div+1) cycles. A value of 0 gives half the system clock.
- R3: `cfg_wsel` picks the word length: 0 gives 8 bits, 1 gives 16 and 2 gives 32 (3 acts as 8). Only the low word-length bits of `tx_data` are sent, most significant of them first.
- R4: Whenever no word is in flight, `sck` rests at the level of `cfg_cpol`. A 1 means an idle-high clock.
- R5: With `cfg_cke`=1 the first `sck` transition of a word comes at mid-bit, moving away from idle. With `cfg_cke`=0 the clock leaves idle at the start of each bit and returns at mid-bit. With polarity 0 and edge-select 1 (mode 0), and with polarity 1 and edge-select 0 (mode 3), the mid-bit edge is rising and the first edge of a word is rising in mode 0 and falling in mode 3.
- R6: With `cfg_smp_end`=0, `miso` is sampled at mid-bit; with 1, it is sampled at the end of the bit. On the final sample of a word the engine raises `rx_push` for exactly one cycle, with `rx_data` holding the word right-aligned and zero-extended.
- R7: A word starts, with a single-cycle `tx_pop`, only when the engine is idle, `cfg_on` and `cfg_master` are both 1 and `tx_empty` is 0. With `cfg_master`=0, no word starts.
- R8: With `cfg_hw_ss`=1, `ss_n` is 0 while a word is in flight or the transmit queue is non-empty, and it returns to 1 once the queue is empty and the last word has finished. With `cfg_hw_ss`=0, `ss_n` stays 1.
- R9: One cycle after `cfg_on` is seen low, the engine has abandoned any word in flight: `busy` is 0, `sck` is at its idle level, and that word produces no `rx_push`.
- R10: In the cycle right after a cycle with `cfg_on` low, no word may start, even if `cfg_on` is high again. The earliest `tx_pop` comes two cycles after `cfg_on` returns.
- R11: `busy` rises together with `tx_pop` and falls at the end of the last bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on | input | 1 | Module on; low halts the engine |
| cfg_master | input | 1 | Master enable; required to start words |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cke | input | 1 | Edge select (1: first edge at mid-bit) |
| cfg_smp_end | input | 1 | Sample point (0: mid-bit, 1: end of bit) |
| cfg_wsel | input | 2 | Word size code |
| cfg_div | input | DIV_W | Clock divider value |
| cfg_hw_ss | input | 1 | Engine-driven slave select enable |
| tx_empty | input | 1 | Transmit queue empty flag |
| tx_data | input | DATA_W | Transmit queue head word |
| tx_pop | output | 1 | Pop strobe to the transmit queue |
| rx_push | output | 1 | Push strobe to the receive queue |
| rx_data | output | DATA_W | Received word, zero-extended |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Word in flight |

## Verification
The properties assume that the queue holds `tx_data` and `tx_empty` steady from a pop until the engine is idle again, and that it treats `tx_pop` as a pop of exactly one word. The bench's queue model follows this by updating its head only on the falling clock edge after it sees the pop. The slave model changes `miso` only at bit boundaries. It counts `sck` edges, so both sample points see a settled value. Configuration inputs change only while `cfg_on` is low, except in the disable test, which toggles `cfg_on` alone.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  localparam int WORD_MAX = 32;

  typedef enum logic [1:0] {
    WSEL_8  = 2'd0,
    WSEL_16 = 2'd1,
    WSEL_32 = 2'd2,
    WSEL_RSV = 2'd3
  } wsel_e;

  function automatic int word_bits(input logic [1:0] code);
    case (wsel_e'(code))
      WSEL_16: return 16;
      WSEL_32: return 32;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_div.sv
`timescale 1ns/1ps
module spi_eng_div #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_eng_rx.sv
`timescale 1ns/1ps
module spi_eng_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              last,
  input  logic              miso,
  output logic              push,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      push <= 1'b0;
      data <= '0;
    end else begin
      push <= 1'b0;
      if (clear) begin
        sh_q <= '0;
      end else if (sample) begin
        sh_q <= {sh_q[DATA_W-2:0], miso};
        if (last) begin
          data <= {sh_q[DATA_W-2:0], miso};
          push <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DATA_W = spi_eng_pkg::WORD_MAX,
  parameter int DIV_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_on,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cke,
  input  logic              cfg_smp_end,
  input  logic [1:0]        cfg_wsel,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_hw_ss,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W:0] FULL_BITS = (CNT_W+1)'(DATA_W);

  logic              busy_q, half_q, guard_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              cpol_l, cke_l, smp_l;
  logic [DIV_W-1:0]  div_l;
  logic              tx_pop_q, sck_q, mosi_q, ss_n_q;

  logic              busy_n, half_n, cpol_n, cke_n;
  logic [CNT_W-1:0]  bit_n;
  logic [DATA_W-1:0] sh_n;
  logic              start, tick, samp_now;
  logic [CNT_W:0]    nbits, shamt;

  assign nbits = (CNT_W+1)'(spi_eng_pkg::word_bits(cfg_wsel));
  assign shamt = FULL_BITS - nbits;
  assign start = !busy_q && cfg_on && cfg_master && !tx_empty && !guard_q;

  spi_eng_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (busy_q),
    .limit (div_l),
    .tick  (tick)
  );

  // sample point: mid-bit is the end of the first half, end-of-bit the second
  assign samp_now = tick && (half_q == smp_l) && cfg_on;

  spi_eng_rx #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .sample (samp_now),
    .last   (bit_q == '0),
    .miso   (miso),
    .push   (rx_push),
    .data   (rx_data)
  );

  always_comb begin
    busy_n = busy_q;
    half_n = half_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    cpol_n = cpol_l;
    cke_n  = cke_l;
    if (!cfg_on) begin
      busy_n = 1'b0;
    end else if (start) begin
      busy_n = 1'b1;
      half_n = 1'b0;
      bit_n  = CNT_W'(nbits - 1'b1);
      sh_n   = tx_data << shamt;
      cpol_n = cfg_cpol;
      cke_n  = cfg_cke;
    end else if (tick) begin
      if (!half_q) begin
        half_n = 1'b1;
      end else begin
        half_n = 1'b0;
        if (bit_q == '0) begin
          busy_n = 1'b0;
        end else begin
          bit_n = bit_q - 1'b1;
          sh_n  = {sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      half_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      cpol_l   <= 1'b0;
      cke_l    <= 1'b0;
      smp_l    <= 1'b0;
      div_l    <= '0;
      guard_q  <= 1'b1;
      tx_pop_q <= 1'b0;
      sck_q    <= cfg_cpol;
      mosi_q   <= 1'b0;
      ss_n_q   <= 1'b1;
    end else begin
      busy_q   <= busy_n;
      half_q   <= half_n;
      bit_q    <= bit_n;
      sh_q     <= sh_n;
      cpol_l   <= cpol_n;
      cke_l    <= cke_n;
      if (start) begin
        smp_l <= cfg_smp_end;
        div_l <= cfg_div;
      end
      guard_q  <= !cfg_on;
      tx_pop_q <= start;
      sck_q    <= busy_n ? (cpol_n ^ (cke_n ? half_n : !half_n)) : cfg_cpol;
      mosi_q   <= busy_n & sh_n[DATA_W-1];
      ss_n_q   <= !(cfg_hw_ss && cfg_on && cfg_master && (busy_n || !tx_empty));
    end
  end

  assign busy   = busy_q;
  assign tx_pop = tx_pop_q;
  assign sck    = sck_q;
  assign mosi   = mosi_q;
  assign ss_n   = ss_n_q;
endmodule

// File: rtl/spi_shift_engine_chk.sv
`timescale 1ns/1ps
module spi_shift_engine_chk (
  input logic clk,
  input logic rst,
  input logic cfg_on,
  input logic cfg_master,
  input logic cfg_cpol,
  input logic cfg_hw_ss,
  input logic tx_empty,
  input logic tx_pop,
  input logic rx_push,
  input logic sck,
  input logic ss_n,
  input logic busy
);
  // R7
  pop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (busy && !$past(busy)));

  // R7
  pop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(cfg_on && cfg_master && !tx_empty));

  // R6
  push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);

  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck == $past(cfg_cpol)));

  // R8
  ss_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_hw_ss) |-> ss_n);

  // R9
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_on) |-> (!busy && !rx_push && !tx_pop));

  // R10
  guard_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_on, 2) |-> !tx_pop);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_on     (cfg_on),
  .cfg_master (cfg_master),
  .cfg_cpol   (cfg_cpol),
  .cfg_hw_ss  (cfg_hw_ss),
  .tx_empty   (tx_empty),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .sck        (sck),
  .ss_n       (ss_n),
  .busy       (busy)
);

// File: tb/spi_shift_engine_bench.sv
`timescale 1ns/1ps
module spi_shift_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_on = 1'b0, cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cke = 1'b1;
  logic        cfg_smp_end = 1'b0, cfg_hw_ss = 1'b0;
  logic [1:0]  cfg_wsel = 2'd0;
  logic [8:0]  cfg_div = 9'd0;
  logic        tx_empty, tx_pop, rx_push, sck, mosi, ss_n, busy;
  logic        miso = 1'b0;
  logic [31:0] tx_data, rx_data;

  logic [31:0] fq [0:7];
  int          head = 0, count = 0;
  assign tx_empty = (count == 0);
  assign tx_data  = fq[head % 8];

  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;
  logic [31:0] mosi_cap, rx_got, miso_word;
  int          nfall, pushes = 0, first_dir, rise_n, nb = 8;
  int          rise_cyc [0:1];
  logic        prev_sck = 1'b0, cur_cpol = 1'b0;

  always #10 clk = ~clk;

  spi_shift_engine u_spi_shift_engine (
    .clk(clk), .rst(rst), .cfg_on(cfg_on), .cfg_master(cfg_master),
    .cfg_cpol(cfg_cpol), .cfg_cke(cfg_cke), .cfg_smp_end(cfg_smp_end),
    .cfg_wsel(cfg_wsel), .cfg_div(cfg_div), .cfg_hw_ss(cfg_hw_ss),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // queue model and SPI slave model, all on the falling clock edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (tx_pop) begin
        head++; count--;
        nfall = 0; mosi_cap = 0; first_dir = 0; rise_n = 0;
      end
      if (sck != prev_sck) begin
        if (sck) begin
          mosi_cap = {mosi_cap[30:0], mosi};
          if (first_dir == 0) first_dir = 1;
          if (rise_n < 2) rise_cyc[rise_n] = cyc;
          rise_n++;
        end else begin
          nfall++;
          if (first_dir == 0) first_dir = 2;
        end
      end
      prev_sck = sck;
      if (rx_push) begin pushes++; rx_got = rx_data; end
      begin
        int idx;
        idx = cur_cpol ? ((nfall == 0) ? 0 : nfall - 1) : nfall;
        if (idx > nb - 1) idx = nb - 1;
        miso = miso_word[nb - 1 - idx];
      end
    end
  end

  function automatic logic [31:0] mask_of(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic push_word(input logic [31:0] w);
    fq[(head + count) % 8] = w;
    count++;
  endtask

  task automatic wait_word(input int p0);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (pushes > p0 && !busy) break;
    end
  endtask

  task automatic run_word(input logic cpol, input logic cke, input logic smp,
                          input logic [1:0] ws, input logic [8:0] dv,
                          input logic [31:0] txw, input logic [31:0] mw, input string req);
    int p0;
    logic [31:0] m;
    @(negedge clk);
    cfg_on = 0; cfg_cpol = cpol; cfg_cke = cke; cfg_smp_end = smp;
    cfg_wsel = ws; cfg_div = dv;
    nb = (ws == 2'd1) ? 16 : (ws == 2'd2) ? 32 : 8;
    cur_cpol = cpol; miso_word = mw;
    m = mask_of(nb);
    repeat (3) @(negedge clk);
    push_word(txw);
    p0 = pushes;
    cfg_on = 1;
    wait_word(p0);
    chk(mosi_cap == (txw & m), {req, " mosi word"}, mosi_cap, txw & m);
    chk(rx_got == (mw & m), {req, " rx word"}, rx_got, mw & m);
    chk(pushes == p0 + 1, {req, " one push"}, 32'(pushes - p0), 32'd1);
    chk(first_dir == ((cpol && !cke) ? 2 : 1), {req, " first edge"}, 32'(first_dir),
        (cpol && !cke) ? 32'd2 : 32'd1);
    chk(rise_cyc[1] - rise_cyc[0] == 2 * (int'(dv) + 1), {req, " sck period"},
        32'(rise_cyc[1] - rise_cyc[0]), 32'(2 * (int'(dv) + 1)));
    @(negedge clk);
    cfg_on = 0;
  endtask

  task automatic t_reset();
    cfg_cpol = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(tx_pop == 0 && rx_push == 0, "R1 strobes", {30'd0, tx_pop, rx_push}, 0);
    chk(mosi == 0, "R1 mosi", 32'(mosi), 0);
    chk(ss_n == 1, "R1 ss_n", 32'(ss_n), 1);
    chk(sck == 1, "R1 sck", 32'(sck), 1);
    cfg_cpol = 0;
    repeat (2) @(negedge clk);
    chk(sck == 0, "R4 idle sck follows polarity", 32'(sck), 0);
  endtask

  task automatic t_master_off();
    int p0;
    @(negedge clk);
    cfg_master = 0;
    push_word(32'h1234_5678);
    p0 = head;
    cfg_on = 1;
    repeat (20) @(negedge clk);
    chk(head == p0 && busy == 0, "R7 master off no start", 32'(head - p0), 0);
    cfg_on = 0;
    @(negedge clk);
    cfg_master = 1;
    count = 0; head = 0;
  endtask

  task automatic t_hw_ss();
    bit ok_low = 1;
    @(negedge clk);
    cfg_cpol = 0; cfg_cke = 1; cfg_wsel = 0; cfg_div = 0; cfg_hw_ss = 0;
    cur_cpol = 0; nb = 8;
    push_word(32'h0000_00F0);
    cfg_on = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!ss_n) ok_low = 0;
    end
    chk(ok_low, "R8 ss_n stays high when disabled", 32'(ok_low), 1);
    cfg_on = 0;
    @(negedge clk);
    cfg_hw_ss = 1;
    push_word(32'h0000_0011);
    push_word(32'h0000_0022);
    ok_low = 1;
    cfg_on = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_pop) break;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy && count == 0) break;
      if (ss_n) ok_low = 0;
    end
    chk(ok_low, "R8 ss_n low across queued words", 32'(ok_low), 1);
    chk(ss_n == 1, "R8 ss_n released when empty", 32'(ss_n), 1);
    cfg_on = 0; cfg_hw_ss = 0;
    @(negedge clk);
  endtask

  task automatic t_disable();
    int p0;
    @(negedge clk);
    cfg_cpol = 0; cfg_cke = 1; cfg_smp_end = 0; cfg_wsel = 2; cfg_div = 9'd10;
    cur_cpol = 0; nb = 32; miso_word = 32'h0F0F_3C3C;
    push_word(32'hDEAD_BEEF);
    push_word(32'h8001_7FFE);
    p0 = pushes;
    cfg_on = 1;
    repeat (40) @(negedge clk);
    chk(busy == 1, "R11 busy mid-word", 32'(busy), 1);
    cfg_on = 0;
    @(negedge clk);
    chk(busy == 0, "R9 halt clears busy", 32'(busy), 0);
    chk(sck == 0, "R9 halt idles sck", 32'(sck), 0);
    cfg_on = 1;
    @(negedge clk);
    chk(tx_pop == 0 && busy == 0, "R10 no start right after disable", 32'(tx_pop), 0);
    @(negedge clk);
    chk(tx_pop == 1, "R10 start two cycles after re-enable", 32'(tx_pop), 1);
    wait_word(p0);
    chk(pushes == p0 + 1, "R9 aborted word not pushed", 32'(pushes - p0), 1);
    chk(mosi_cap == 32'h8001_7FFE, "R3 word after restart", mosi_cap, 32'h8001_7FFE);
    chk(rx_got == 32'h0F0F_3C3C, "R6 rx after restart", rx_got, 32'h0F0F_3C3C);
    chk(busy == 0, "R11 busy low after word", 32'(busy), 0);
    cfg_on = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_word(0, 1, 0, 2'd0, 9'd0, 32'hA5A5_A5C3, 32'h0000_005A, "R2 R3 R5 R6 mode0 8b div0 mid");
    run_word(0, 1, 1, 2'd1, 9'd3, 32'hFFFF_B00B, 32'h1234_C0DE, "R2 R3 R6 mode0 16b end");
    run_word(1, 0, 0, 2'd2, 9'd1, 32'h8123_4561, 32'hCAFE_F00D, "R3 R4 R5 R6 mode3 32b mid");
    run_word(1, 0, 1, 2'd0, 9'd2, 32'h0000_0001, 32'hFFFF_FF80, "R5 R6 mode3 8b end");
    run_word(0, 1, 0, 2'd3, 9'd0, 32'h0000_FF7E, 32'h0000_0081, "R3 code3 acts as 8b");
    t_master_off();
    t_hw_ss();
    t_disable();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule